// File: doc/BRIEF.md
# Decode-Stage Direct Jump Redirect Checker

This block sits in the decode stage of an out-of-order core and looks at every slot of an incoming decode group in program order. For each slot that is a direct, unconditional control-flow instruction it adds the encoded offset to the slot's PC and compares the result with the next PC that fetch predicted. A slot that fetch marked as predicted-taken but that is not a control-flow instruction at all is also an error. The oldest faulty slot in the group produces a registered redirect packet for fetch. That slot is still forwarded to rename, and every younger slot of the group is cut off.

For a slot that fetch did not predict taken, the predicted next PC is the fall-through address, PC + 4. An unconditional jump that fetch let fall through therefore counts as a mismatch unless its offset is exactly 4. After a redirect the stage spends a fixed number of cycles squashing: groups that arrive in that window are wrong-path and are dropped without being checked. The block also flags forwarded slots that have no source operands as ready to issue, and keeps two saturating counters, one per kind of misprediction. Conditional and indirect control flow pass through unchecked.

Top module: `dec_redirect_check`

## Requirements
- R1: While reset is asserted and on the first cycle after it, every output is zero: no slot forwarded, no slot ready, no redirect, both counters at zero.
- R2: A group with no faulty valid slot is forwarded one cycle after it is presented: bit i of `fwd_en_o` equals bit i of `slot_vld_i`, and `redir_vld_o` stays 0.
- R3: A valid slot with control, direct and unconditional bits all 1 has the target PC + offset (modulo 2^PC_W). If this differs from its effective predicted next PC, a redirect is raised with `redir_cls_o` = 0, `redir_npc_o` = the target and `redir_seq_o` = that slot's sequence number. A matching prediction raises nothing.
- R4: The effective predicted next PC of a slot is `slot_pnpc_i` when `slot_ptkn_i` is 1 and PC + 4 otherwise. `slot_pnpc_i` of a not-taken slot has no effect.
- R5: A valid slot with `slot_ptkn_i` = 1 and `slot_ctrl_i` = 0 raises a redirect with `redir_cls_o` = 1, `redir_npc_o` = PC + 4 and that slot's sequence number.
- R6: The faulty slot is itself forwarded, and no slot with a higher index in the same group is forwarded.
- R7: When several valid slots are faulty, the one with the lowest index determines the redirect packet.
- R8: `issue_rdy_o[i]` is 1 exactly when slot i is forwarded and its source count is zero.
- R9: `redir_vld_o` is high for exactly one cycle per detected error. The SQUASH_CYC groups presented in the cycles after detection are dropped: nothing is forwarded and no redirect is raised, even when they contain faults.
- R10: `tgt_miss_cnt_o` counts redirects of the R3 kind and `cls_miss_cnt_o` counts redirects of the R5 kind. Each saturates at 2^CNT_W - 1, and neither changes in a cycle without a redirect of its kind.
- R11: Invalid slots, conditional control slots and indirect control slots never raise a redirect, whatever their prediction fields hold.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| slot_vld_i | input | SLOTS | Slot holds an instruction |
| slot_pc_i | input | SLOTS*PC_W | PC of each slot |
| slot_pnpc_i | input | SLOTS*PC_W | Predicted next PC from fetch |
| slot_ptkn_i | input | SLOTS | Fetch predicted the slot taken |
| slot_ctrl_i | input | SLOTS | Slot is a control-flow instruction |
| slot_direct_i | input | SLOTS | Target is encoded in the instruction |
| slot_uncond_i | input | SLOTS | Control transfer is unconditional |
| slot_ofs_i | input | SLOTS*PC_W | PC-relative offset of a direct target |
| slot_nsrc_i | input | SLOTS*SRC_W | Number of source operands |
| slot_seq_i | input | SLOTS*SEQ_W | Sequence number of each slot |
| fwd_en_o | output | SLOTS | Slot is passed on to rename |
| issue_rdy_o | output | SLOTS | Forwarded slot may issue at once |
| redir_vld_o | output | 1 | Redirect packet valid (one cycle) |
| redir_cls_o | output | 1 | 1: taken prediction on a non-control slot; 0: wrong jump target |
| redir_seq_o | output | SEQ_W | Sequence number of the offending slot |
| redir_npc_o | output | PC_W | Corrected next PC |
| tgt_miss_cnt_o | output | CNT_W | Saturating count of jump target redirects |
| cls_miss_cnt_o | output | CNT_W | Saturating count of class redirects |

## Verification
The bench builds the block with four slots and a two-cycle squash window, so one group can hold an early clean slot, a faulty slot and younger victims, and each dropped wrong-path group can be checked on its own. It narrows the counters to three bits, which puts saturation at seven redirects within a short directed run. The PC stays at 32 bits, so fall-through and offset sums are checked at full width.

// File: rtl/dec_redir_pkg.sv
package dec_redir_pkg;

    // Fixed instruction length: fall-through step from one PC to the next.
    localparam int unsigned INSN_BYTES = 4;

    // Outcome of checking a single decode slot.
    typedef enum logic [1:0] {
        VERDICT_OK     = 2'd0,
        VERDICT_TARGET = 2'd1,
        VERDICT_CLASS  = 2'd2
    } verdict_e;

endpackage

// File: rtl/dec_slot_eval.sv
module dec_slot_eval
    import dec_redir_pkg::*;
#(
    parameter int unsigned PC_W = 32
) (
    input  logic            vld,
    input  logic [PC_W-1:0] pc,
    input  logic [PC_W-1:0] pnpc,
    input  logic            ptkn,
    input  logic            ctrl,
    input  logic            direct,
    input  logic            uncond,
    input  logic [PC_W-1:0] ofs,
    output verdict_e        verdict,
    output logic [PC_W-1:0] fix_npc
);

    localparam logic [PC_W-1:0] STEP = PC_W'(INSN_BYTES);

    logic [PC_W-1:0] fall_pc;
    logic [PC_W-1:0] jump_tgt;
    logic [PC_W-1:0] eff_pred;
    logic            is_jump;
    logic            class_bad;
    logic            target_bad;

    always_comb begin
        fall_pc    = pc + STEP;
        jump_tgt   = pc + ofs;
        // A slot that fetch did not predict taken is predicted to fall through.
        eff_pred   = ptkn ? pnpc : fall_pc;
        is_jump    = ctrl & direct & uncond;
        class_bad  = ptkn & ~ctrl;
        target_bad = is_jump & (jump_tgt != eff_pred);

        verdict = VERDICT_OK;
        fix_npc = '0;
        if (vld) begin
            if (class_bad) begin
                verdict = VERDICT_CLASS;
                fix_npc = fall_pc;
            end else if (target_bad) begin
                verdict = VERDICT_TARGET;
                fix_npc = jump_tgt;
            end
        end
    end

endmodule

// File: rtl/dec_first_fault.sv
module dec_first_fault #(
    parameter int unsigned SLOTS = 4,
    localparam int unsigned IDX_W = (SLOTS > 1) ? $clog2(SLOTS) : 1
) (
    input  logic [SLOTS-1:0] fault,
    output logic             any,
    output logic [IDX_W-1:0] idx,
    output logic [SLOTS-1:0] keep
);

    // keep[i] is set when no slot older than i is faulty.
    logic [SLOTS:0] older_fault;

    assign older_fault[0] = 1'b0;

    for (genvar g = 0; g < SLOTS; g++) begin : g_chain
        assign older_fault[g+1] = older_fault[g] | fault[g];
        assign keep[g]          = ~older_fault[g];
    end

    assign any = older_fault[SLOTS];

    always_comb begin
        idx = '0;
        for (int i = SLOTS - 1; i >= 0; i--) begin
            if (fault[i]) begin
                idx = IDX_W'(i);
            end
        end
    end

endmodule

// File: rtl/dec_redirect_check.sv
module dec_redirect_check
    import dec_redir_pkg::*;
#(
    parameter int unsigned SLOTS      = 4,
    parameter int unsigned PC_W       = 32,
    parameter int unsigned SEQ_W      = 16,
    parameter int unsigned SRC_W      = 2,
    parameter int unsigned CNT_W      = 16,
    parameter int unsigned SQUASH_CYC = 2
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic [SLOTS-1:0]            slot_vld_i,
    input  logic [SLOTS-1:0][PC_W-1:0]  slot_pc_i,
    input  logic [SLOTS-1:0][PC_W-1:0]  slot_pnpc_i,
    input  logic [SLOTS-1:0]            slot_ptkn_i,
    input  logic [SLOTS-1:0]            slot_ctrl_i,
    input  logic [SLOTS-1:0]            slot_direct_i,
    input  logic [SLOTS-1:0]            slot_uncond_i,
    input  logic [SLOTS-1:0][PC_W-1:0]  slot_ofs_i,
    input  logic [SLOTS-1:0][SRC_W-1:0] slot_nsrc_i,
    input  logic [SLOTS-1:0][SEQ_W-1:0] slot_seq_i,
    output logic [SLOTS-1:0]            fwd_en_o,
    output logic [SLOTS-1:0]            issue_rdy_o,
    output logic                        redir_vld_o,
    output logic                        redir_cls_o,
    output logic [SEQ_W-1:0]            redir_seq_o,
    output logic [PC_W-1:0]             redir_npc_o,
    output logic [CNT_W-1:0]            tgt_miss_cnt_o,
    output logic [CNT_W-1:0]            cls_miss_cnt_o
);

    localparam int unsigned IDX_W = (SLOTS > 1) ? $clog2(SLOTS) : 1;
    localparam int unsigned SQ_W  = $clog2(SQUASH_CYC + 1);
    localparam logic [CNT_W-1:0] CNT_MAX = '1;
    localparam logic [SQ_W-1:0]  SQ_LOAD = SQ_W'(SQUASH_CYC);

    typedef struct packed {
        logic [SLOTS-1:0] fwd;
        logic [SLOTS-1:0] rdy;
        logic             redir;
        logic             cls;
        logic [SEQ_W-1:0] seq;
        logic [PC_W-1:0]  npc;
        logic [SQ_W-1:0]  sq_left;
        logic [CNT_W-1:0] tgt_cnt;
        logic [CNT_W-1:0] cls_cnt;
    } state_t;

    state_t st_d, st_q;

    // Per-slot checks.
    verdict_e                verdict [SLOTS];
    logic [SLOTS-1:0][PC_W-1:0] fix_npc;
    logic [SLOTS-1:0]        fault;
    logic [SLOTS-1:0]        no_src;

    for (genvar g = 0; g < SLOTS; g++) begin : g_slot
        dec_slot_eval #(
            .PC_W (PC_W)
        ) i_eval (
            .vld     (slot_vld_i[g]),
            .pc      (slot_pc_i[g]),
            .pnpc    (slot_pnpc_i[g]),
            .ptkn    (slot_ptkn_i[g]),
            .ctrl    (slot_ctrl_i[g]),
            .direct  (slot_direct_i[g]),
            .uncond  (slot_uncond_i[g]),
            .ofs     (slot_ofs_i[g]),
            .verdict (verdict[g]),
            .fix_npc (fix_npc[g])
        );
        assign fault[g]  = (verdict[g] != VERDICT_OK);
        assign no_src[g] = (slot_nsrc_i[g] == '0);
    end

    // Oldest faulty slot wins.
    logic             any_fault;
    logic [IDX_W-1:0] first_idx;
    logic [SLOTS-1:0] keep_mask;

    dec_first_fault #(
        .SLOTS (SLOTS)
    ) i_first (
        .fault (fault),
        .any   (any_fault),
        .idx   (first_idx),
        .keep  (keep_mask)
    );

    logic active;
    logic fire;
    logic fire_cls;

    always_comb begin
        st_d = st_q;

        // Groups arriving inside the squash window are wrong-path.
        active   = (st_q.sq_left == '0);
        fire     = active & any_fault;
        fire_cls = fire & (verdict[first_idx] == VERDICT_CLASS);

        if (!active) begin
            st_d.sq_left = st_q.sq_left - 1'b1;
        end else if (fire) begin
            st_d.sq_left = SQ_LOAD;
        end

        st_d.fwd = active ? (slot_vld_i & keep_mask) : '0;
        st_d.rdy = st_d.fwd & no_src;

        st_d.redir = fire;
        st_d.cls   = fire_cls;
        st_d.seq   = fire ? slot_seq_i[first_idx] : '0;
        st_d.npc   = fire ? fix_npc[first_idx]    : '0;

        if (fire && !fire_cls && st_q.tgt_cnt != CNT_MAX) begin
            st_d.tgt_cnt = st_q.tgt_cnt + 1'b1;
        end
        if (fire_cls && st_q.cls_cnt != CNT_MAX) begin
            st_d.cls_cnt = st_q.cls_cnt + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign fwd_en_o       = st_q.fwd;
    assign issue_rdy_o    = st_q.rdy;
    assign redir_vld_o    = st_q.redir;
    assign redir_cls_o    = st_q.cls;
    assign redir_seq_o    = st_q.seq;
    assign redir_npc_o    = st_q.npc;
    assign tgt_miss_cnt_o = st_q.tgt_cnt;
    assign cls_miss_cnt_o = st_q.cls_cnt;

endmodule

// File: rtl/dec_redirect_check_chk.sv
module dec_redirect_check_chk #(
    parameter int unsigned SLOTS = 4,
    parameter int unsigned CNT_W = 16
) (
    input logic             clk,
    input logic             rst_n,
    input logic [SLOTS-1:0] fwd_en,
    input logic [SLOTS-1:0] issue_rdy,
    input logic             redir_vld,
    input logic             redir_cls,
    input logic [CNT_W-1:0] tgt_cnt,
    input logic [CNT_W-1:0] cls_cnt
);

    // R9
    redir_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        redir_vld |=> (!redir_vld && fwd_en == '0));

    // R6
    offender_fwd_chk: assert property (@(posedge clk) disable iff (!rst_n)
        redir_vld |-> (fwd_en != '0));

    // R8
    issue_subset_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (issue_rdy & ~fwd_en) == '0);

    // R10
    cnt_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !redir_vld |-> ($stable(tgt_cnt) && $stable(cls_cnt)));

    // R10
    cnt_kind_chk: assert property (@(posedge clk) disable iff (!rst_n)
        redir_vld |-> (redir_cls ? $stable(tgt_cnt) : $stable(cls_cnt)));

endmodule

bind dec_redirect_check dec_redirect_check_chk #(
    .SLOTS (SLOTS),
    .CNT_W (CNT_W)
) i_dec_redirect_check_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .fwd_en    (fwd_en_o),
    .issue_rdy (issue_rdy_o),
    .redir_vld (redir_vld_o),
    .redir_cls (redir_cls_o),
    .tgt_cnt   (tgt_miss_cnt_o),
    .cls_cnt   (cls_miss_cnt_o)
);

// File: tb/test_dec_redirect_check.sv
`timescale 1ns/1ps
module test_dec_redirect_check;

    localparam int unsigned S     = 4;
    localparam int unsigned PC_W  = 32;
    localparam int unsigned SEQ_W = 16;
    localparam int unsigned SRC_W = 2;
    localparam int unsigned CNT_W = 3;
    localparam int unsigned SQ    = 2;
    localparam int unsigned CMAX  = 7;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #2.5 clk = ~clk;

    logic [S-1:0]            vld, ptkn, ctrl, dir, unc;
    logic [S-1:0][PC_W-1:0]  pc, pnpc, ofs;
    logic [S-1:0][SRC_W-1:0] nsrc;
    logic [S-1:0][SEQ_W-1:0] seq;
    logic [S-1:0]            fwd, rdy;
    logic                    rv, rcls;
    logic [SEQ_W-1:0]        rseq;
    logic [PC_W-1:0]         rnpc;
    logic [CNT_W-1:0]        tcnt, ccnt;

    dec_redirect_check #(
        .SLOTS(S), .PC_W(PC_W), .SEQ_W(SEQ_W), .SRC_W(SRC_W),
        .CNT_W(CNT_W), .SQUASH_CYC(SQ)
    ) i_dec_redirect_check (
        .clk(clk), .rst_n(rst_n),
        .slot_vld_i(vld), .slot_pc_i(pc), .slot_pnpc_i(pnpc),
        .slot_ptkn_i(ptkn), .slot_ctrl_i(ctrl), .slot_direct_i(dir),
        .slot_uncond_i(unc), .slot_ofs_i(ofs), .slot_nsrc_i(nsrc),
        .slot_seq_i(seq),
        .fwd_en_o(fwd), .issue_rdy_o(rdy), .redir_vld_o(rv),
        .redir_cls_o(rcls), .redir_seq_o(rseq), .redir_npc_o(rnpc),
        .tgt_miss_cnt_o(tcnt), .cls_miss_cnt_o(ccnt)
    );

    int n_chk = 0;
    int n_fail = 0;
    int exp_t = 0;
    int exp_c = 0;
    bit done = 1'b0;

    task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic cyc;
        @(negedge clk);
    endtask

    task automatic clr;
        vld = '0; ptkn = '0; ctrl = '0; dir = '0; unc = '0;
        pc = '0; pnpc = '0; ofs = '0; nsrc = '0; seq = '0;
    endtask

    task automatic plain(input int i, input logic [31:0] p, input logic [15:0] s, input logic [1:0] ns);
        vld[i] = 1'b1; pc[i] = p; seq[i] = s; nsrc[i] = ns;
    endtask

    task automatic jump(input int i, input logic [31:0] p, input logic [31:0] o,
                        input logic tk, input logic [31:0] pn, input logic [15:0] s);
        vld[i] = 1'b1; ctrl[i] = 1'b1; dir[i] = 1'b1; unc[i] = 1'b1;
        pc[i] = p; ofs[i] = o; ptkn[i] = tk; pnpc[i] = pn; seq[i] = s; nsrc[i] = 2'd1;
    endtask

    task automatic drain;
        clr;
        repeat (SQ) cyc;
    endtask

    task automatic bump_t;
        if (exp_t < CMAX) exp_t++;
    endtask

    task automatic t_reset;
        chk("R1 fwd", 64'(fwd), 0);
        chk("R1 rdy", 64'(rdy), 0);
        chk("R1 redir", 64'(rv), 0);
        chk("R1 cnt", 64'({tcnt, ccnt}), 0);
    endtask

    task automatic t_clean;
        clr;
        plain(0, 32'h1000, 16'd1, 2'd1);
        plain(1, 32'h1004, 16'd2, 2'd0);
        plain(2, 32'h1008, 16'd3, 2'd2);
        plain(3, 32'h100c, 16'd4, 2'd0);
        cyc;
        chk("R2 fwd", 64'(fwd), 64'b1111);
        chk("R2 redir", 64'(rv), 0);
        chk("R8 rdy", 64'(rdy), 64'b1010);
        // gap in the group: slot1 empty
        clr;
        plain(0, 32'h1010, 16'd5, 2'd0);
        plain(2, 32'h1018, 16'd7, 2'd1);
        cyc;
        chk("R2 fwd gap", 64'(fwd), 64'b0101);
        chk("R8 rdy gap", 64'(rdy), 64'b0001);
    endtask

    task automatic t_target_and_squash;
        clr;
        plain(0, 32'h0fc, 16'd10, 2'd0);
        jump(1, 32'h100, 32'h40, 1'b1, 32'h200, 16'd11);
        plain(2, 32'h104, 16'd12, 2'd0);
        plain(3, 32'h108, 16'd13, 2'd0);
        cyc;
        bump_t;
        chk("R3 redir", 64'(rv), 1);
        chk("R3 cls", 64'(rcls), 0);
        chk("R3 npc", 64'(rnpc), 64'h140);
        chk("R3 seq", 64'(rseq), 64'd11);
        chk("R6 fwd", 64'(fwd), 64'b0011);
        chk("R8 rdy trunc", 64'(rdy), 64'b0001);
        chk("R10 tgt cnt", 64'(tcnt), 64'(exp_t));
        // R9: two wrong-path groups dropped, even when faulty
        clr;
        plain(0, 32'h500, 16'd20, 2'd0);
        ptkn[0] = 1'b1;
        cyc;
        chk("R9 redir one cycle", 64'(rv), 0);
        chk("R9 drop1 fwd", 64'(fwd), 0);
        clr;
        jump(0, 32'h600, 32'h8, 1'b0, 32'h0, 16'd21);
        cyc;
        chk("R9 drop2 redir", 64'(rv), 0);
        chk("R9 drop2 fwd", 64'(fwd), 0);
        chk("R10 no count in squash", 64'({tcnt, ccnt}), 64'({3'(exp_t), 3'(exp_c)}));
        clr;
        plain(0, 32'h700, 16'd22, 2'd0);
        plain(1, 32'h704, 16'd23, 2'd0);
        cyc;
        chk("R9 resume fwd", 64'(fwd), 64'b0011);
        chk("R9 resume redir", 64'(rv), 0);
    endtask

    task automatic t_fallthrough;
        clr;
        jump(0, 32'h300, 32'h4, 1'b0, 32'hdead, 16'd30);
        jump(1, 32'h304, 32'h8, 1'b0, 32'h30c, 16'd31);
        plain(2, 32'h30c, 16'd32, 2'd0);
        cyc;
        bump_t;
        chk("R4 redir", 64'(rv), 1);
        chk("R4 seq", 64'(rseq), 64'd31);
        chk("R4 npc", 64'(rnpc), 64'h30c);
        chk("R4 fwd", 64'(fwd), 64'b0011);
        drain;
    endtask

    task automatic t_class_oldest;
        clr;
        plain(0, 32'h800, 16'd40, 2'd1);
        plain(1, 32'h804, 16'd41, 2'd1);
        plain(2, 32'h808, 16'd42, 2'd0);
        ptkn[2] = 1'b1; pnpc[2] = 32'h900;
        jump(3, 32'h80c, 32'h100, 1'b1, 32'h0, 16'd43);
        cyc;
        exp_c++;
        chk("R5 cls", 64'(rcls), 1);
        chk("R5 npc", 64'(rnpc), 64'h80c);
        chk("R7 seq oldest", 64'(rseq), 64'd42);
        chk("R6 fwd", 64'(fwd), 64'b0111);
        chk("R10 cls cnt", 64'(ccnt), 64'(exp_c));
        chk("R10 tgt hold", 64'(tcnt), 64'(exp_t));
        drain;
    endtask

    task automatic t_ignored;
        clr;
        // slot0 invalid but carries a class fault
        ptkn[0] = 1'b1; pc[0] = 32'ha00;
        // slot1 conditional direct branch with a wrong prediction
        vld[1] = 1'b1; ctrl[1] = 1'b1; dir[1] = 1'b1; ptkn[1] = 1'b1;
        pc[1] = 32'ha04; ofs[1] = 32'h10; pnpc[1] = 32'hbeef; seq[1] = 16'd51;
        // slot2 indirect unconditional jump with a wrong prediction
        vld[2] = 1'b1; ctrl[2] = 1'b1; unc[2] = 1'b1; ptkn[2] = 1'b1;
        pc[2] = 32'ha08; ofs[2] = 32'h20; pnpc[2] = 32'hcafe; seq[2] = 16'd52;
        // slot3 jump predicted correctly
        jump(3, 32'ha0c, 32'h44, 1'b1, 32'ha50, 16'd53);
        cyc;
        chk("R11 redir", 64'(rv), 0);
        chk("R11 fwd", 64'(fwd), 64'b1110);
        chk("R3 correct pred", 64'(tcnt), 64'(exp_t));
    endtask

    task automatic t_saturate;
        for (int k = 0; k < 7; k++) begin
            clr;
            jump(0, 32'h2000 + 32'(k * 16), 32'h80, 1'b1, 32'h0, 16'(60 + k));
            cyc;
            bump_t;
            chk("R10 sat step", 64'(tcnt), 64'(exp_t));
            drain;
        end
        chk("R10 saturated", 64'(tcnt), 64'(CMAX));
    endtask

    task automatic finish_run;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            finish_run;
        end
    end

    initial begin
        clr;
        repeat (3) cyc;
        t_reset;
        rst_n = 1'b1;
        t_reset;
        t_clean;
        t_target_and_squash;
        t_fallthrough;
        t_class_oldest;
        t_ignored;
        t_saturate;
        done = 1'b1;
        finish_run;
    end

endmodule